// File: doc/BRIEF.md
# Programmable PIO Cycle Timing Generator

This block is the host-side sequencer for one programmed-I/O access on a parallel disk interface. A client raises a request carrying a read/write flag, a pair of chip-select enables, a 3-bit register index and, for writes, the data word. The block then runs a single bus cycle with four phases. First it presents the device address. Then it pulls the matching active-low strobe down. After the strobe rises it keeps the address and write data in place. Finally it leaves the bus quiet before reporting completion with a one-clock acknowledge.

Software sets the length of every phase, in clock cycles, through configuration inputs. The same logic therefore covers slow and fast transfer modes. A floor on the total cycle length keeps slow modes legal even when the individual phases are short. The device can stretch the strobe by holding its ready line low. If ready stays low past a programmable limit, the access is abandoned and flagged. The data path is 16 bits wide, and a narrow setting confines it to the low byte.

Top module: `pio_cycle_gen`

## Requirements
- R1: After reset, and whenever no access is in progress, req_ready is 1, bus_cs_n is 2'b11, bus_rd_n and bus_wr_n are 1, bus_doe is 0 and ack is 0.
- R2: bus_cs_n (equal to the inverse of req_cs) and bus_addr (equal to req_reg) are driven for max(cfg_setup,1) cycles before the strobe falls, and they do not change while the strobe is low.
- R3: When ready is high, the strobe stays low for max(cfg_pulse,1) cycles. A read lowers only bus_rd_n, a write lowers only bus_wr_n, and the two are never low together.
- R4: After the strobe rises, the chip selects, the address and, for a write, bus_dout with bus_doe=1 stay in place for max(cfg_hold,1) cycles. Then the chip selects return to 2'b11 and bus_doe to 0.
- R5: The number of cycles with req_ready=0 is max(S+P+E+H+max(cfg_recov,1), max(cfg_cycle,1)), where S, P and H are the phase lengths above and E is the number of extension cycles. With cfg_cycle=120 on a 5 ns clock, an access lasts at least 600 ns.
- R6: A request is taken only in a cycle where req_ready=1. ack is high for exactly one cycle, which is the first cycle with req_ready=1 after the access. A req_valid raised while busy changes nothing on the bus and produces no extra ack.
- R7: The device's ready line is checked in the last minimum strobe cycle and in every cycle after it. If it reads low on L consecutive checks, with L ≤ max(cfg_timeout,1), the strobe stays low for P+L cycles and ack_err is 0.
- R8: If ready is still low on the check made after T=max(cfg_timeout,1) extension cycles, the strobe is released after P+T low cycles. The hold and recovery phases still run, ack_err is 1 with ack, and ack_rdata is 0.
- R9: With cfg_narrow=0 at request time, all 16 data bits are moved. With cfg_narrow=1, a write drives bus_dout[15:8]=0 and a read returns ack_rdata[15:8]=0 with bus_din[7:0] in the low byte.
- R10: A read returns, on ack_rdata, the bus_din value present in the last strobe-low cycle, which is the value at the edge where the strobe rises. A write returns ack_rdata=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_setup | input | TW | Address setup cycles before the strobe (0 counts as 1) |
| cfg_pulse | input | TW | Minimum strobe low cycles (0 counts as 1) |
| cfg_hold | input | TW | Address/data hold cycles after the strobe (0 counts as 1) |
| cfg_recov | input | TW | Strobe-high recovery cycles (0 counts as 1) |
| cfg_cycle | input | TW | Minimum total access cycles (0 counts as 1) |
| cfg_timeout | input | TOW | Allowed ready-extension cycles (0 counts as 1) |
| cfg_narrow | input | 1 | 1 selects the 8-bit data path |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_cs | input | 2 | Chip-select enables, active high |
| req_reg | input | 3 | Register index |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Block is idle and will accept a request |
| ack | output | 1 | One-cycle completion pulse |
| ack_rdata | output | 16 | Read result, valid with ack |
| ack_err | output | 1 | Ready timeout occurred, valid with ack |
| bus_cs_n | output | 2 | Active-low chip selects |
| bus_addr | output | 3 | Register address |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_dout | output | 16 | Write data toward the device |
| bus_doe | output | 1 | Write data drive enable |
| bus_din | input | 16 | Read data from the device |
| bus_iordy | input | 1 | Device ready, low stretches the strobe |

## Verification
Every bus output is registered. The address appears in the first cycle after the accepting edge, and each later phase boundary falls exactly one phase-length later. The bench therefore counts phase lengths by sampling once per cycle at the falling clock edge, after each register has settled. The device model drives ready at that falling edge for the check made on the next rising edge, so an extension of L cycles lines up with the R7 arithmetic. The acknowledge is due in the first cycle where req_ready returns high, and the bench samples it in that cycle and again one cycle later to confirm it is a single pulse.

// File: rtl/pio_pkg.sv
package pio_pkg;
    parameter int DATA_W = 16;
    parameter int HALF_W = DATA_W / 2;
    parameter int CS_W   = 2;
    parameter int REG_W  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_RECOV
    } pio_state_e;

    typedef struct packed {
        pio_state_e              state;
        logic [CS_W-1:0]         cs_n;
        logic [REG_W-1:0]        addr;
        logic                    rd_n;
        logic                    wr_n;
        logic [DATA_W-1:0]       dout;
        logic                    doe;
        logic                    write;
        logic                    narrow;
        logic [DATA_W-1:0]       rdata;
        logic                    ack;
        logic                    err;
    } pio_regs_t;
endpackage

// File: rtl/pio_span_counter.sv
module pio_span_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = (load_val == '0) ? W'(1) : load_val;
        end else if (cnt_q > W'(1)) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q <= W'(1));

    // R2/R3/R4: a freshly loaded phase never ends in less than one cycle
    assert_load_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q != '0);
endmodule

// File: rtl/pio_elapsed.sv
module pio_elapsed #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         busy,
    input  logic [W-1:0] limit,
    output logic         reached
);
    localparam int EW = W + 1;
    logic [EW-1:0] el_d, el_q;
    logic [EW-1:0] lim_n;

    assign lim_n = (limit == '0) ? EW'(1) : {1'b0, limit};

    always_comb begin
        el_d = el_q;
        if (start) begin
            el_d = EW'(1);
        end else if (busy && (el_q != '1)) begin
            el_d = el_q + EW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) el_q <= '0;
        else        el_q <= el_d;
    end

    assign reached = (el_q >= lim_n);

    // R5: the elapsed count restarts at one on each new access
    assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> el_q == EW'(1));
endmodule

// File: rtl/pio_wait_guard.sv
module pio_wait_guard #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] wc_d, wc_q;
    logic [W-1:0] lim_n;

    assign lim_n = (limit == '0) ? W'(1) : limit;

    always_comb begin
        wc_d = wc_q;
        if (clr) begin
            wc_d = '0;
        end else if (inc && (wc_q != '1)) begin
            wc_d = wc_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wc_q <= '0;
        else        wc_q <= wc_d;
    end

    assign expired = (wc_q >= lim_n);

    // R7: cleared guard is never reported expired in the following cycle
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !expired);
endmodule

// File: rtl/pio_cycle_gen.sv
module pio_cycle_gen
    import pio_pkg::*;
#(
    parameter int TW  = 8,
    parameter int TOW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TW-1:0]     cfg_setup,
    input  logic [TW-1:0]     cfg_pulse,
    input  logic [TW-1:0]     cfg_hold,
    input  logic [TW-1:0]     cfg_recov,
    input  logic [TW-1:0]     cfg_cycle,
    input  logic [TOW-1:0]    cfg_timeout,
    input  logic              cfg_narrow,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              ack,
    output logic [DATA_W-1:0] ack_rdata,
    output logic              ack_err,
    output logic [CS_W-1:0]   bus_cs_n,
    output logic [REG_W-1:0]  bus_addr,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              bus_iordy
);
    localparam pio_regs_t RST = '{
        state:  ST_IDLE,
        cs_n:   '1,
        addr:   '0,
        rd_n:   1'b1,
        wr_n:   1'b1,
        dout:   '0,
        doe:    1'b0,
        write:  1'b0,
        narrow: 1'b0,
        rdata:  '0,
        ack:    1'b0,
        err:    1'b0
    };

    pio_regs_t r_d, r_q;

    logic          span_load;
    logic [TW-1:0] span_val;
    logic          span_last;
    logic          start;
    logic          reached;
    logic          guard_clr;
    logic          guard_inc;
    logic          expired;

    pio_span_counter #(.W(TW)) u_span (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (span_load),
        .load_val (span_val),
        .last     (span_last)
    );

    pio_elapsed #(.W(TW)) u_elapsed (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .busy    (r_q.state != ST_IDLE),
        .limit   (cfg_cycle),
        .reached (reached)
    );

    pio_wait_guard #(.W(TOW)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (guard_clr),
        .inc     (guard_inc),
        .limit   (cfg_timeout),
        .expired (expired)
    );

    assign guard_clr = (r_q.state != ST_PULSE) || !span_last;
    assign guard_inc = (r_q.state == ST_PULSE) && span_last && !bus_iordy;

    always_comb begin
        r_d       = r_q;
        r_d.ack   = 1'b0;
        span_load = 1'b0;
        span_val  = '0;
        start     = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    start      = 1'b1;
                    span_load  = 1'b1;
                    span_val   = cfg_setup;
                    r_d.state  = ST_SETUP;
                    r_d.cs_n   = ~req_cs;
                    r_d.addr   = req_reg;
                    r_d.write  = req_write;
                    r_d.narrow = cfg_narrow;
                    r_d.dout   = cfg_narrow ? {{HALF_W{1'b0}}, req_wdata[HALF_W-1:0]}
                                            : req_wdata;
                    r_d.doe    = req_write;
                    r_d.err    = 1'b0;
                    r_d.rdata  = '0;
                end
            end
            ST_SETUP: begin
                if (span_last) begin
                    span_load = 1'b1;
                    span_val  = cfg_pulse;
                    r_d.state = ST_PULSE;
                    r_d.rd_n  = r_q.write;
                    r_d.wr_n  = !r_q.write;
                end
            end
            ST_PULSE: begin
                if (span_last && (bus_iordy || expired)) begin
                    span_load = 1'b1;
                    span_val  = cfg_hold;
                    r_d.state = ST_HOLD;
                    r_d.rd_n  = 1'b1;
                    r_d.wr_n  = 1'b1;
                    if (!bus_iordy) begin
                        r_d.err = 1'b1;
                    end else if (!r_q.write) begin
                        r_d.rdata = r_q.narrow ? {{HALF_W{1'b0}}, bus_din[HALF_W-1:0]}
                                               : bus_din;
                    end
                end
            end
            ST_HOLD: begin
                if (span_last) begin
                    span_load = 1'b1;
                    span_val  = cfg_recov;
                    r_d.state = ST_RECOV;
                    r_d.cs_n  = '1;
                    r_d.doe   = 1'b0;
                    r_d.dout  = '0;
                end
            end
            ST_RECOV: begin
                if (span_last && reached) begin
                    r_d.state = ST_IDLE;
                    r_d.ack   = 1'b1;
                end
            end
            default: r_d = RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RST;
        else        r_q <= r_d;
    end

    assign req_ready = (r_q.state == ST_IDLE);
    assign ack       = r_q.ack;
    assign ack_rdata = r_q.rdata;
    assign ack_err   = r_q.ack & r_q.err;
    assign bus_cs_n  = r_q.cs_n;
    assign bus_addr  = r_q.addr;
    assign bus_rd_n  = r_q.rd_n;
    assign bus_wr_n  = r_q.wr_n;
    assign bus_dout  = r_q.dout;
    assign bus_doe   = r_q.doe;

    assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_n || bus_wr_n);

    assert_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_rd_n) || $fell(bus_wr_n)) |-> ($stable(bus_addr) && $stable(bus_cs_n)));

    assert_addr_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_rd_n && bus_wr_n) && !$past(bus_rd_n && bus_wr_n)) |-> $stable(bus_addr));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_rd_n) || $rose(bus_wr_n)) |-> $stable(bus_cs_n));

    assert_wdata_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_wr_n) |-> ($stable(bus_dout) && bus_doe));

    assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    assert_ack_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> req_ready);

    assert_narrow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_doe && r_q.narrow) |-> (bus_dout[DATA_W-1:HALF_W] == '0));

    assert_err_rdata_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_err |-> (ack_rdata == '0));
endmodule

// File: tb/sim_pio_cycle_gen.sv
module sim_pio_cycle_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_setup = '0, cfg_pulse = '0, cfg_hold = '0, cfg_recov = '0, cfg_cycle = '0;
    logic [7:0]  cfg_timeout = '0;
    logic        cfg_narrow = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_cs = '0;
    logic [2:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, ack, ack_err;
    logic [15:0] ack_rdata;
    logic [1:0]  bus_cs_n;
    logic [2:0]  bus_addr;
    logic        bus_rd_n, bus_wr_n, bus_doe;
    logic [15:0] bus_dout;
    logic [15:0] bus_din = '0;
    logic        bus_iordy = 1'b1;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pio_cycle_gen u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse), .cfg_hold(cfg_hold),
        .cfg_recov(cfg_recov), .cfg_cycle(cfg_cycle), .cfg_timeout(cfg_timeout),
        .cfg_narrow(cfg_narrow),
        .req_valid(req_valid), .req_write(req_write), .req_cs(req_cs),
        .req_reg(req_reg), .req_wdata(req_wdata),
        .req_ready(req_ready), .ack(ack), .ack_rdata(ack_rdata), .ack_err(ack_err),
        .bus_cs_n(bus_cs_n), .bus_addr(bus_addr), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_din(bus_din), .bus_iordy(bus_iordy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int nz(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic run_txn(input bit wr, input logic [1:0] cs, input logic [2:0] rg,
                           input logic [15:0] wd, input logic [15:0] pat, input bit nar,
                           input int s, input int p, input int h, input int r,
                           input int c, input int t, input int lowlen, input bit inject);
        int sn = nz(s), pn = nz(p), hn = nz(h), rn = nz(r), cn = nz(c), tn = nz(t);
        int ext = (lowlen > tn) ? tn : lowlen;
        bit exp_err = (lowlen > tn);
        int exp_total = sn + pn + ext + hn + rn;
        int setup_c = 0, low_c = 0, hold_c = 0, busy_c = 0, it = 0;
        bit seen_low = 1'b0, addr_ok = 1'b1, strobe_ok = 1'b1, wd_ok = 1'b1;
        logic [15:0] exp_wd = nar ? {8'h00, wd[7:0]} : wd;
        logic [15:0] exp_rd = (wr || exp_err) ? 16'h0 : (nar ? {8'h00, pat[7:0]} : pat);
        if (cn > exp_total) exp_total = cn;
        @(negedge clk);
        cfg_setup = 8'(s); cfg_pulse = 8'(p); cfg_hold = 8'(h); cfg_recov = 8'(r);
        cfg_cycle = 8'(c); cfg_timeout = 8'(t); cfg_narrow = nar;
        req_write = wr; req_cs = cs; req_reg = rg; req_wdata = wd; bus_din = pat;
        chk(req_ready === 1'b1, "R6", "ready before request", req_ready, 1);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        req_reg = ~rg;
        req_wdata = ~wd;
        while (!req_ready && it < 3000) begin
            busy_c++;
            if (!bus_rd_n || !bus_wr_n) begin
                low_c++;
                seen_low = 1'b1;
                if (bus_addr !== rg || bus_cs_n !== ~cs) addr_ok = 1'b0;
                if (wr ? (bus_wr_n !== 1'b0 || bus_rd_n !== 1'b1)
                       : (bus_rd_n !== 1'b0 || bus_wr_n !== 1'b1)) strobe_ok = 1'b0;
                if (wr && (bus_doe !== 1'b1 || bus_dout !== exp_wd)) wd_ok = 1'b0;
                bus_iordy = (low_c >= pn + lowlen);
            end else begin
                bus_iordy = 1'b1;
                if (bus_cs_n !== 2'b11) begin
                    if (bus_addr !== rg || bus_cs_n !== ~cs) addr_ok = 1'b0;
                    if (!seen_low) setup_c++;
                    else begin
                        hold_c++;
                        if (wr && (bus_doe !== 1'b1 || bus_dout !== exp_wd)) wd_ok = 1'b0;
                    end
                end else if (bus_doe !== 1'b0) begin
                    wd_ok = 1'b0;
                end
            end
            req_valid = (inject && busy_c == 2);
            @(negedge clk);
            it++;
        end
        req_valid = 1'b0;
        bus_iordy = 1'b1;
        chk(setup_c == sn, "R2", "setup cycles", setup_c, sn);
        chk(addr_ok, "R2", "address/select value and stability", addr_ok, 1);
        chk(strobe_ok, "R3", "strobe polarity", strobe_ok, 1);
        chk(low_c == pn + ext, exp_err ? "R8" : (lowlen > 0 ? "R7" : "R3"),
            "strobe low cycles", low_c, pn + ext);
        chk(hold_c == hn, "R4", "hold cycles", hold_c, hn);
        if (wr) chk(wd_ok, nar ? "R9" : "R4", "write data drive", wd_ok, 1);
        chk(busy_c == exp_total, "R5", "busy cycles", busy_c, exp_total);
        chk(ack === 1'b1, "R6", "ack in first idle cycle", ack, 1);
        chk(ack_err === exp_err, exp_err ? "R8" : "R7", "ack_err", ack_err, exp_err);
        chk(ack_rdata === exp_rd, nar ? "R9" : "R10", "read data", ack_rdata, exp_rd);
        chk(bus_cs_n === 2'b11 && bus_doe === 1'b0, "R1", "idle bus", bus_cs_n, 3);
        @(negedge clk);
        chk(ack === 1'b0 && req_ready === 1'b1, "R6", "ack single pulse", ack, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=expired expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready === 1'b1 && ack === 1'b0, "R1", "reset handshake", {req_ready, ack}, 2);
        chk(bus_cs_n === 2'b11 && bus_rd_n === 1'b1 && bus_wr_n === 1'b1 && bus_doe === 1'b0,
            "R1", "reset bus", {bus_cs_n, bus_rd_n, bus_wr_n, bus_doe}, 5'b11110);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(req_ready === 1'b1 && bus_cs_n === 2'b11, "R1", "idle after reset", req_ready, 1);

        // Sweep every phase setting 0..3
        for (int i = 0; i < 256; i++) begin
            run_txn(i[0], (i[1] ? 2'b01 : 2'b10), 3'(i), 16'(16'h3C5A ^ (i * 97)),
                    16'(16'hB2E1 ^ (i * 131)), i[2],
                    i & 3, (i >> 2) & 3, (i >> 4) & 3, (i >> 6) & 3, 0, 4, 0, (i % 37) == 5);
        end

        // R5: total-cycle floor, including the 600 ns slow-mode case (120 x 5 ns)
        run_txn(1'b0, 2'b01, 3'd7, 16'h0, 16'h1234, 1'b0, 1, 2, 1, 1, 20, 4, 0, 1'b0);
        run_txn(1'b1, 2'b10, 3'd0, 16'hBEEF, 16'h0, 1'b0, 3, 8, 2, 4, 120, 4, 0, 1'b0);

        // R7: ready extension within the limit
        for (int l = 1; l <= 4; l++) begin
            run_txn(l[0], 2'b01, 3'(l), 16'hA000 + 16'(l), 16'h5A00 + 16'(l), 1'b0,
                    1, 2, 1, 1, 0, 4, l, 1'b0);
        end
        // R8: timeout, read and write, and zero limit counted as one
        run_txn(1'b0, 2'b01, 3'd2, 16'h0, 16'hFFFF, 1'b0, 1, 2, 1, 1, 0, 4, 9, 1'b0);
        run_txn(1'b1, 2'b10, 3'd5, 16'h7E81, 16'h0, 1'b1, 2, 1, 2, 1, 0, 3, 6, 1'b0);
        run_txn(1'b0, 2'b11, 3'd6, 16'h0, 16'hC3C3, 1'b1, 1, 1, 1, 1, 0, 0, 2, 1'b0);
        run_txn(1'b0, 2'b11, 3'd6, 16'h0, 16'h9669, 1'b0, 1, 1, 1, 1, 0, 0, 1, 1'b0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule